// File: doc/BRIEF.md
# Branch Target Buffer with Two-Level Direction Predictor

This block sits in an instruction fetch stage and guesses, for each fetch address, whether a branch lives there, whether it will be taken, and where it goes. It holds a 4-way set-associative table of branch entries. Each entry keeps a target address and four 2-bit saturating direction counters. A 2-bit global history of recent conditional outcomes picks one of the four counters. When a fetch address misses, fetch continues sequentially. A separate decode-time port applies a static rule instead: a branch whose target lies below its own address is guessed taken, and any other branch is guessed not taken.

A lookup presented with `lk_valid` is answered one cycle later on the `rsp_*` pins, and `rsp_valid` marks the answer. The predictor accepts a lookup and an update every cycle. There is no back-pressure and so no ready pins, and neither stream may stall. Resolved branches arrive on the `up_*` port, one per cycle at most, to train the table. An update applied in the same cycle as a lookup is already visible to that lookup's answer. `rsp_bubble` flags taken predictions, and the front end charges one bubble cycle for each of them.

Top module: `bp_btb_predictor`

## Requirements
- R1: After reset the table is empty and the history is 00. Every lookup misses, with `rsp_taken`=0 and `rsp_target` = fetch PC + 4.
- R2: `rsp_valid` is high in the cycle after `lk_valid` and in no other cycle. `rsp_hit` is 1 when a valid way of set PC[8:2] holds the tag {PC[31:9], PC[1:0]}.
- R3: A taken conditional update that misses allocates an entry with the given tag and target. Its counter selected by the current history is set to 10, and its other three counters are set to 01.
- R4: A not-taken conditional update that misses leaves the table unchanged. An unconditional update (`up_uncond`=1) changes neither the table nor the history.
- R5: On a hit, the counter selected by the current history gives the direction, taken when its MSB is 1. A conditional update that hits moves that counter up by one if taken and down by one if not, saturating at 11 and 00.
- R6: Every conditional update shifts the history left by one and places the outcome (1 for taken) in bit 0. The counter updated is the one selected by the history before the shift.
- R7: `rsp_target` is the stored target when the lookup is predicted taken, and fetch PC + 4 otherwise. A taken conditional update that hits rewrites the stored target.
- R8: `rsp_bubble` is 1 exactly when the response is a hit predicted taken.
- R9: Allocation uses the lowest-numbered empty way of the set. If the set is full, it uses the way named by a 3-bit tree pseudo-LRU. Tree bit 0 picks a half (0 = ways 0/1). Bit 1 picks within ways 0/1 and bit 2 picks within ways 2/3 (0 = lower way). Every hit or allocation by an update points the bits on that way's path away from it.
- R10: An update and a lookup presented in the same cycle: the lookup's answer already reflects the update, including the new history.
- R11: `sq_taken` is 1 when `sq_target` < `sq_pc` (unsigned), and 0 otherwise. It is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Fetch address to look up |
| rsp_valid | output | 1 | Response to last cycle's lookup |
| rsp_hit | output | 1 | Lookup found an entry |
| rsp_taken | output | 1 | Predicted taken |
| rsp_target | output | 32 | Predicted next fetch address |
| rsp_bubble | output | 1 | Taken prediction, costs one bubble cycle |
| up_valid | input | 1 | Resolved branch this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Actual direction |
| up_target | input | 32 | Actual target |
| up_uncond | input | 1 | Branch is unconditional |
| sq_pc | input | 32 | Decode-time branch address |
| sq_target | input | 32 | Decode-time branch target |
| sq_taken | output | 1 | Static direction guess |

## Verification
The bench goes after these corner cases:
- Counter selection across history values. A design that indexed with the post-shift history, or shifted on unconditional jumps, would predict taken one branch too early or too late.
- Same-cycle update and lookup on the same entry. Reading stale state here shows up as a miss on an address just allocated.
- A fifth allocation into a full set. A wrong tree walk evicts a recently trained way, so a lookup expected to hit misses.
- Heavy random mixes over two crowded sets, compared each cycle against a behavioural model. These expose saturation slips, target rewrites on not-taken updates, and allocation on not-taken or unconditional branches.

// File: rtl/bp_pkg.sv
package bp_pkg;
  parameter int PC_W_DEF = 32;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // saturating step of a direction counter
  function automatic ctr_e ctr_step(ctr_e c, logic taken);
    if (taken) return (c == CTR_ST) ? CTR_ST : ctr_e'(c + 2'd1);
    else       return (c == CTR_SNT) ? CTR_SNT : ctr_e'(c - 2'd1);
  endfunction
endpackage

// File: rtl/bp_way_match.sv
module bp_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 25,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0]            vld,
  input  logic [TAG_W-1:0]           key,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = vld[w] && (tags[w] == key);
  end

  always_comb begin
    hit = |eq;
    way = '0;
    for (int w = 0; w < WAYS; w++)
      if (eq[w]) way = WAY_W'(w);
  end
endmodule

// File: rtl/bp_plru.sv
module bp_plru #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  tree,
  input  logic [WAYS-1:0]  vld,
  input  logic [WAY_W-1:0] touch,
  output logic [WAY_W-1:0] victim,
  output logic [WAYS-2:0]  tree_nxt
);
  logic [2*WAYS-2:0] path;

  // walk the tree: node n has children 2n+1 (bit 0) and 2n+2 (bit 1)
  always_comb begin
    path = '0;
    path[0] = 1'b1;
    for (int n = 0; n < WAYS-1; n++) begin
      path[2*n+1] = path[n] & ~tree[n];
      path[2*n+2] = path[n] &  tree[n];
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (path[w+WAYS-1]) victim = WAY_W'(w);
    for (int w = 0; w < WAYS; w++)
      if (!found && !vld[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
  end

  // point every node on the touched way's path away from it
  always_comb begin
    tree_nxt = tree;
    for (int w = 0; w < WAYS; w++)
      if (touch == WAY_W'(w))
        for (int l = 0; l < WAY_W; l++)
          tree_nxt[(1 << l) - 1 + (w >> (WAY_W - l))] = ~((w >> (WAY_W - 1 - l)) & 1);
  end
endmodule

// File: rtl/bp_static_dir.sv
module bp_static_dir #(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] target,
  output logic            taken
);
  // backward branch guessed taken, forward guessed not taken
  assign taken = target < pc;
endmodule

// File: rtl/bp_btb_predictor.sv
module bp_btb_predictor
  import bp_pkg::*;
#(
  parameter int PC_W      = PC_W_DEF,
  parameter int SETS_LOG2 = 7,
  parameter int WAYS      = 4,
  parameter int HIST_W    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_taken,
  output logic [PC_W-1:0] rsp_target,
  output logic            rsp_bubble,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target,
  input  logic            up_uncond,
  input  logic [PC_W-1:0] sq_pc,
  input  logic [PC_W-1:0] sq_target,
  output logic            sq_taken
);
  localparam int SETS   = 1 << SETS_LOG2;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int IDX_HI = SETS_LOG2 + 1;
  localparam int TAG_W  = PC_W - SETS_LOG2;
  localparam int NCTR   = 1 << HIST_W;

  // entry storage
  logic              v_q    [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [PC_W-1:0]   tgt_q  [SETS][WAYS];
  ctr_e              ctr_q  [SETS][WAYS][NCTR];
  logic [WAYS-2:0]   tree_q [SETS];
  logic [HIST_W-1:0] hist_q;

  // lookup stage register
  logic              rv_q;
  logic [PC_W-1:0]   pc_q;

  // ---------------- update side ----------------
  logic [SETS_LOG2-1:0]         u_idx;
  logic [TAG_W-1:0]             u_key;
  logic [WAYS-1:0][TAG_W-1:0]   u_tags;
  logic [WAYS-1:0]              u_vld;
  logic                         u_hit;
  logic [WAY_W-1:0]             u_hway, u_victim, u_way;
  logic [WAYS-2:0]              u_tree_nxt;
  logic                         u_cond, u_alloc, u_touch;

  assign u_idx = up_pc[IDX_HI:2];
  assign u_key = {up_pc[PC_W-1:IDX_HI+1], up_pc[1:0]};

  for (genvar w = 0; w < WAYS; w++) begin : g_uread
    assign u_tags[w] = tag_q[u_idx][w];
    assign u_vld[w]  = v_q[u_idx][w];
  end

  bp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_umatch (
    .tags(u_tags), .vld(u_vld), .key(u_key), .hit(u_hit), .way(u_hway)
  );

  bp_plru #(.WAYS(WAYS)) u_plru (
    .tree(tree_q[u_idx]), .vld(u_vld), .touch(u_way),
    .victim(u_victim), .tree_nxt(u_tree_nxt)
  );

  assign u_cond  = up_valid & ~up_uncond;
  assign u_alloc = u_cond & ~u_hit & up_taken;
  assign u_touch = u_cond & (u_hit | up_taken);
  assign u_way   = u_hit ? u_hway : u_victim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      rv_q   <= 1'b0;
      pc_q   <= '0;
      for (int s = 0; s < SETS; s++) begin
        tree_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) v_q[s][w] <= 1'b0;
      end
    end else begin
      rv_q <= lk_valid;
      if (lk_valid) pc_q <= lk_pc;
      if (u_cond) hist_q <= {hist_q[HIST_W-2:0], up_taken};
      if (u_touch) tree_q[u_idx] <= u_tree_nxt;
      if (u_alloc) v_q[u_idx][u_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (u_touch) begin
      if (u_alloc) begin
        tag_q[u_idx][u_way] <= u_key;
        for (int c = 0; c < NCTR; c++)
          ctr_q[u_idx][u_way][c] <= (c == int'(hist_q)) ? CTR_WT : CTR_WNT;
      end else begin
        ctr_q[u_idx][u_way][hist_q] <= ctr_step(ctr_q[u_idx][u_way][hist_q], up_taken);
      end
      if (up_taken) tgt_q[u_idx][u_way] <= up_target;
    end
  end

  // ---------------- lookup side ----------------
  logic [SETS_LOG2-1:0]       l_idx;
  logic [TAG_W-1:0]           l_key;
  logic [WAYS-1:0][TAG_W-1:0] l_tags;
  logic [WAYS-1:0]            l_vld;
  logic                       l_hit;
  logic [WAY_W-1:0]           l_way;
  ctr_e                       l_ctr;
  logic                       l_taken;

  assign l_idx = pc_q[IDX_HI:2];
  assign l_key = {pc_q[PC_W-1:IDX_HI+1], pc_q[1:0]};

  for (genvar w = 0; w < WAYS; w++) begin : g_lread
    assign l_tags[w] = tag_q[l_idx][w];
    assign l_vld[w]  = v_q[l_idx][w];
  end

  bp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lmatch (
    .tags(l_tags), .vld(l_vld), .key(l_key), .hit(l_hit), .way(l_way)
  );

  assign l_ctr   = ctr_q[l_idx][l_way][hist_q];
  assign l_taken = rv_q & l_hit & l_ctr[1];

  assign rsp_valid  = rv_q;
  assign rsp_hit    = rv_q & l_hit;
  assign rsp_taken  = l_taken;
  assign rsp_target = l_taken ? tgt_q[l_idx][l_way] : pc_q + PC_W'(4);
  assign rsp_bubble = l_taken;

  bp_static_dir #(.PC_W(PC_W)) u_static (
    .pc(sq_pc), .target(sq_target), .taken(sq_taken)
  );
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [PC_W-1:0]   lk_pc,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_taken,
  input logic [PC_W-1:0]   rsp_target,
  input logic              rsp_bubble,
  input logic              up_valid,
  input logic              up_taken,
  input logic              up_uncond,
  input logic [HIST_W-1:0] hist_q
);
  a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  a_r2_hit_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  a_r7_fallthrough_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_taken) |-> rsp_target == $past(lk_pc) + PC_W'(4));

  a_r8_bubble_on_taken_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_bubble |-> (rsp_hit && rsp_taken));

  a_r6_history_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_uncond) |=> hist_q[0] == $past(up_taken));

  a_r4_history_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_valid && !up_uncond) |=> $stable(hist_q));
endmodule

bind bp_btb_predictor bp_checker #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_taken(rsp_taken),
  .rsp_target(rsp_target), .rsp_bubble(rsp_bubble), .up_valid(up_valid),
  .up_taken(up_taken), .up_uncond(up_uncond), .hist_q(hist_q)
);

// File: tb/sim_bp_btb_predictor.sv
`timescale 1ns/1ps
module sim_bp_btb_predictor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_pc;
  logic        rsp_valid, rsp_hit, rsp_taken, rsp_bubble;
  logic [31:0] rsp_target;
  logic        up_valid, up_taken, up_uncond;
  logic [31:0] up_pc, up_target;
  logic [31:0] sq_pc, sq_target;
  logic        sq_taken;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bp_btb_predictor u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_taken(rsp_taken),
    .rsp_target(rsp_target), .rsp_bubble(rsp_bubble),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_target(up_target), .up_uncond(up_uncond),
    .sq_pc(sq_pc), .sq_target(sq_target), .sq_taken(sq_taken)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit          m_v   [128][4];
  int unsigned m_key [128][4];
  logic [31:0] m_tgt [128][4];
  int          m_ctr [128][4][4];
  int          m_tr  [128][3];
  int          m_hist;
  bit          e_valid, e_hit, e_taken;
  logic [31:0] e_target;

  function automatic int unsigned key_of(logic [31:0] pc);
    return ((pc >> 9) << 2) | (pc & 32'h3);
  endfunction

  function automatic int find_way(int s, int unsigned k);
    for (int w = 0; w < 4; w++) if (m_v[s][w] && m_key[s][w] == k) return w;
    return -1;
  endfunction

  task automatic m_touch(int s, int w);
    if (w < 2) begin m_tr[s][0] = 1; m_tr[s][1] = (w == 0); end
    else       begin m_tr[s][0] = 0; m_tr[s][2] = (w == 2); end
  endtask

  task automatic m_update(logic [31:0] pc, bit tk, logic [31:0] tg);
    int s, w;
    s = int'((pc >> 2) & 32'h7f);
    w = find_way(s, key_of(pc));
    if (w >= 0) begin
      if (tk && m_ctr[s][w][m_hist] < 3) m_ctr[s][w][m_hist]++;
      if (!tk && m_ctr[s][w][m_hist] > 0) m_ctr[s][w][m_hist]--;
      if (tk) m_tgt[s][w] = tg;
      m_touch(s, w);
    end else if (tk) begin
      w = -1;
      for (int i = 3; i >= 0; i--) if (!m_v[s][i]) w = i;
      if (w < 0) w = (m_tr[s][0] == 0) ? m_tr[s][1] : 2 + m_tr[s][2];
      m_v[s][w] = 1; m_key[s][w] = key_of(pc); m_tgt[s][w] = tg;
      for (int c = 0; c < 4; c++) m_ctr[s][w][c] = (c == m_hist) ? 2 : 1;
      m_touch(s, w);
    end
    m_hist = ((m_hist << 1) | int'(tk)) & 3;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 128; s++) begin
        for (int w = 0; w < 4; w++) m_v[s][w] = 0;
        for (int b = 0; b < 3; b++) m_tr[s][b] = 0;
      end
      m_hist = 0; e_valid = 0;
    end else begin
      if (up_valid && !up_uncond) m_update(up_pc, up_taken, up_target);
      e_valid = lk_valid;
      if (lk_valid) begin
        int s, w;
        s = int'((lk_pc >> 2) & 32'h7f);
        w = find_way(s, key_of(lk_pc));
        e_hit    = (w >= 0);
        e_taken  = e_hit && m_ctr[s][w][m_hist] >= 2;
        e_target = e_taken ? m_tgt[s][w] : lk_pc + 32'd4;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 rsp_valid", 32'(rsp_valid), 32'(e_valid));
      if (e_valid) begin
        chk("R2 hit", 32'(rsp_hit), 32'(e_hit));
        chk("R5 taken", 32'(rsp_taken), 32'(e_taken));
        chk("R7 target", rsp_target, e_target);
        chk("R8 bubble", 32'(rsp_bubble), 32'(e_taken));
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic upd(logic [31:0] pc, bit tk, logic [31:0] tg, bit unc);
    @(negedge clk);
    up_valid = 1; up_pc = pc; up_taken = tk; up_target = tg; up_uncond = unc;
    @(negedge clk);
    up_valid = 0;
  endtask

  task automatic look(string req, logic [31:0] pc, bit hit, bit tk, logic [31:0] tg, bit all);
    @(negedge clk);
    lk_valid = 1; lk_pc = pc;
    @(negedge clk);
    lk_valid = 0;
    chk(req, 32'(rsp_hit), 32'(hit));
    if (all) begin
      chk(req, 32'(rsp_taken), 32'(tk));
      chk(req, rsp_target, tg);
      chk(req, 32'(rsp_bubble), 32'(tk));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 0; lk_valid = 0; lk_pc = 0; up_valid = 0; up_pc = 0;
    up_taken = 0; up_target = 0; up_uncond = 0; sq_pc = 0; sq_target = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset, fall-through target
    look("R1 reset miss", 32'h100, 0, 0, 32'h104, 1);

    // R11: static rule
    sq_pc = 32'h1000; sq_target = 32'h0F00; #1;
    chk("R11 backward taken", 32'(sq_taken), 1);
    sq_target = 32'h1100; #1;
    chk("R11 forward not taken", 32'(sq_taken), 0);
    sq_target = 32'h1000; #1;
    chk("R11 equal not taken", 32'(sq_taken), 0);

    // R4: no allocation on not-taken miss or unconditional
    upd(32'h1000, 0, 32'h0, 0);
    look("R4 not-taken miss no alloc", 32'h1000, 0, 0, 32'h1004, 1);
    upd(32'h2000, 1, 32'h3000, 1);
    look("R4 uncond no alloc", 32'h2000, 0, 0, 32'h2004, 1);

    // R3: allocation at history 00, lookup at history 01 sees weak counter
    upd(32'h1000, 1, 32'h0800, 0);
    look("R3 alloc hit weak counter", 32'h1000, 1, 0, 32'h1004, 1);
    // R6: history 10 selects another weak counter
    upd(32'h5000, 0, 32'h0, 0);
    look("R6 history 10", 32'h1000, 1, 0, 32'h1004, 1);
    // R6/R5/R7/R8: history back to 00 selects the trained counter
    upd(32'h5000, 0, 32'h0, 0);
    look("R5 R7 R8 trained counter taken", 32'h1000, 1, 1, 32'h0800, 1);

    // R10: update and lookup of the same address in one cycle
    @(negedge clk);
    up_valid = 1; up_pc = 32'h6000; up_taken = 1; up_target = 32'h6800; up_uncond = 0;
    lk_valid = 1; lk_pc = 32'h6000;
    @(negedge clk);
    up_valid = 0; lk_valid = 0;
    chk("R10 same-cycle hit", 32'(rsp_hit), 1);
    chk("R10 same-cycle new history", 32'(rsp_taken), 0);

    // R9: five allocations into set 4
    for (int k = 0; k < 5; k++) upd(32'h10010 + 32'(k) * 32'h200, 1, 32'h7000, 0);
    look("R9 oldest evicted", 32'h10010, 0, 0, 0, 0);
    look("R9 second kept", 32'h10210, 1, 0, 0, 0);
    look("R9 newest kept", 32'h10810, 1, 0, 0, 0);

    // R5/R7 random mix over two crowded sets, checked by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      lk_valid  = $urandom_range(0, 3) != 0;
      lk_pc     = (32'($urandom_range(0, 5)) << 9) | (32'($urandom_range(0, 1)) << 2) | 32'h20000;
      up_valid  = $urandom_range(0, 1) == 1;
      up_pc     = (32'($urandom_range(0, 5)) << 9) | (32'($urandom_range(0, 1)) << 2) | 32'h20000;
      up_taken  = $urandom_range(0, 2) != 0;
      up_target = 32'($urandom_range(0, 255)) << 4;
      up_uncond = $urandom_range(0, 5) == 0;
    end
    @(negedge clk);
    lk_valid = 0; up_valid = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule